// File: doc/BRIEF.md
# Exact Recency Tracker with Bit-Matrix Ordering

This block keeps the exact least-recently-used order of a set of frames and reports the oldest one at all times. It stores one bit for every ordered pair of frames. The bit in row r, column c is 1 when frame r was touched more recently than frame c. A replacement engine sends each frame reference to the touch port. It reads the victim index from `lru_idx` whenever it needs one.

A drop port retires a frame. The dropped frame becomes the next victim, so a freed slot is refilled first. The number of frames is a parameter, and the default is 8.

Each cycle, a small decoder turns the inputs into one of four named operations:

- `OP_CLEAR` is taken while `rst` is high.
- `OP_DROP` is taken when `drop_valid` is high.
- `OP_TOUCH` is taken when only `touch_valid` is high.
- `OP_IDLE` is taken otherwise.

The operations are mutually exclusive and are checked in that priority order. There is no sequence between them: each cycle selects one operation afresh, and the matrix update for it lands on the next clock edge. The victim is chosen by combinational logic from the stored matrix.

Top module: `lru_matrix_tracker`

## Requirements
- R1: A high `rst` at a clock edge clears every matrix bit, and it overrides a touch or drop in that cycle. After this edge `lru_idx` reads 0.
- R2: A touch of frame k sets all bits of row k to 1 and then clears all bits of column k, including bit (k,k). Frame k becomes the most recent, so with more than one frame it is not reported as the victim after that edge.
- R3: Each row is read as an unsigned number with column 0 as its most significant bit. `lru_idx` names the row with the smallest number. When rows tie, the lowest index wins, so frames that were never touched are reported lowest index first.
- R4: A drop of frame k clears row k and sets bit k in every other row. After that edge, frame k is the unique victim, and the relative order of the other frames is unchanged.
- R5: When a touch and a drop arrive in the same cycle, the drop is applied and the touch is discarded without any effect on the order.
- R6: At most one operation is applied per clock. `lru_idx` reflects every operation up to the most recent edge. A cycle with neither strobe leaves `lru_idx` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset that clears the matrix |
| touch_valid | input | 1 | Strobe: frame `touch_idx` was referenced this cycle |
| touch_idx | input | $clog2(N) | Frame referenced |
| drop_valid | input | 1 | Strobe: frame `drop_idx` is retired this cycle |
| drop_idx | input | $clog2(N) | Frame retired |
| lru_idx | output | $clog2(N) | Current least-recently-used frame |

## Verification
The assertions take for granted that N is at least 2 and that both index inputs are always below N. Without these conditions, the check that a touched frame is no longer the victim would be meaningless. Every index in the stimulus is drawn from 0 to N-1, and the default N of 8 makes every 3-bit code legal. The stimulus also combines touches and drops in the same cycle and places resets in the middle of traffic. These cases exercise the priority order, which the assertions treat as fixed.

// File: rtl/lru_pkg.sv
package lru_pkg;

    // Operation applied to the matrix at the next clock edge
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_TOUCH = 2'd1,
        OP_DROP  = 2'd2,
        OP_CLEAR = 2'd3
    } mx_op_e;

endpackage

// File: rtl/lru_op_decode.sv
module lru_op_decode
    import lru_pkg::*;
#(
    parameter int N     = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             rst,
    input  logic             touch_valid,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic             drop_valid,
    input  logic [IDX_W-1:0] drop_idx,
    output mx_op_e           op,
    output logic [IDX_W-1:0] op_idx
);

    // Priority: clear over drop over touch (R1, R5)
    always_comb begin
        op     = OP_IDLE;
        op_idx = touch_idx;
        if (rst) begin
            op = OP_CLEAR;
        end else if (drop_valid) begin
            op     = OP_DROP;
            op_idx = drop_idx;
        end else if (touch_valid) begin
            op = OP_TOUCH;
        end
    end

endmodule

// File: rtl/lru_matrix_store.sv
module lru_matrix_store
    import lru_pkg::*;
#(
    parameter int N     = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic                   clk,
    input  mx_op_e                 op,
    input  logic [IDX_W-1:0]       op_idx,
    output logic [N-1:0][N-1:0]    rows
);

    // rows[r][c] = 1 : frame r more recent than frame c
    always_ff @(posedge clk) begin
        unique case (op)
            OP_CLEAR: begin
                rows <= '0;
            end
            OP_TOUCH: begin
                for (int r = 0; r < N; r++) begin
                    for (int c = 0; c < N; c++) begin
                        if (IDX_W'(r) == op_idx) begin
                            rows[r][c] <= (IDX_W'(c) != op_idx);
                        end else if (IDX_W'(c) == op_idx) begin
                            rows[r][c] <= 1'b0;
                        end
                    end
                end
            end
            OP_DROP: begin
                for (int r = 0; r < N; r++) begin
                    for (int c = 0; c < N; c++) begin
                        if (IDX_W'(r) == op_idx) begin
                            rows[r][c] <= 1'b0;
                        end else if (IDX_W'(c) == op_idx) begin
                            rows[r][c] <= 1'b1;
                        end
                    end
                end
            end
            OP_IDLE: begin
            end
        endcase
    end

endmodule

// File: rtl/lru_min_select.sv
module lru_min_select #(
    parameter int N     = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0][N-1:0] rows,
    output logic [IDX_W-1:0]    lru_idx
);

    // Row value with column 0 as the most significant bit (R3)
    logic [N-1:0][N-1:0] key;

    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            assign key[r][N-1-c] = rows[r][c];
        end
    end

    logic [N-1:0] best_val;

    // Strict compare keeps the lowest index on ties
    always_comb begin
        best_val = key[0];
        lru_idx  = '0;
        for (int r = 1; r < N; r++) begin
            if (key[r] < best_val) begin
                best_val = key[r];
                lru_idx  = IDX_W'(r);
            end
        end
    end

endmodule

// File: rtl/lru_matrix_tracker.sv
module lru_matrix_tracker
    import lru_pkg::*;
#(
    parameter int N     = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch_valid,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic             drop_valid,
    input  logic [IDX_W-1:0] drop_idx,
    output logic [IDX_W-1:0] lru_idx
);

    mx_op_e              op;
    logic [IDX_W-1:0]    op_idx;
    logic [N-1:0][N-1:0] rows;

    lru_op_decode #(.N(N)) u_decode (
        .rst         (rst),
        .touch_valid (touch_valid),
        .touch_idx   (touch_idx),
        .drop_valid  (drop_valid),
        .drop_idx    (drop_idx),
        .op          (op),
        .op_idx      (op_idx)
    );

    lru_matrix_store #(.N(N)) u_store (
        .clk    (clk),
        .op     (op),
        .op_idx (op_idx),
        .rows   (rows)
    );

    lru_min_select #(.N(N)) u_select (
        .rows    (rows),
        .lru_idx (lru_idx)
    );

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (lru_idx == '0));

    // R2
    touched_not_lru_chk: assert property (@(posedge clk) disable iff (rst)
        (touch_valid && !drop_valid) |=> (lru_idx != $past(touch_idx)));

    // R4
    dropped_is_lru_chk: assert property (@(posedge clk) disable iff (rst)
        drop_valid |=> (lru_idx == $past(drop_idx)));

    // R6
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!touch_valid && !drop_valid) |=> $stable(lru_idx));

endmodule

// File: tb/lru_matrix_tracker_test.sv
module lru_matrix_tracker_test;

    localparam int N     = 8;
    localparam int IDX_W = $clog2(N);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             touch_valid = 1'b0;
    logic [IDX_W-1:0] touch_idx = '0;
    logic             drop_valid = 1'b0;
    logic [IDX_W-1:0] drop_idx = '0;
    logic [IDX_W-1:0] lru_idx;

    always #2 clk = ~clk;

    lru_matrix_tracker #(.N(N)) uut (
        .clk         (clk),
        .rst         (rst),
        .touch_valid (touch_valid),
        .touch_idx   (touch_idx),
        .drop_valid  (drop_valid),
        .drop_idx    (drop_idx),
        .lru_idx     (lru_idx)
    );

    typedef struct {
        int    exp;
        string tag;
    } item_t;

    item_t sb_q[$];
    int    n_vec  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    // Reference model: recency stamps
    int stamp [N];
    int hi_cnt = 0;
    int lo_cnt = 0;

    function automatic int model_lru();
        int best = 0;
        for (int i = 1; i < N; i++) begin
            if (stamp[i] < stamp[best]) best = i;
        end
        return best;
    endfunction

    task automatic step(input bit r, input bit tv, input int ti,
                        input bit dv, input int di, input string tag);
        item_t it;
        @(negedge clk);
        rst         = r;
        touch_valid = tv;
        touch_idx   = IDX_W'(ti);
        drop_valid  = dv;
        drop_idx    = IDX_W'(di);
        if (r) begin
            for (int i = 0; i < N; i++) stamp[i] = 0;
            hi_cnt = 0;
            lo_cnt = 0;
        end else if (dv) begin
            lo_cnt    = lo_cnt - 1;
            stamp[di] = lo_cnt;
        end else if (tv) begin
            hi_cnt    = hi_cnt + 1;
            stamp[ti] = hi_cnt;
        end
        it.exp = model_lru();
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic touch(input int k, input string tag);
        step(1'b0, 1'b1, k, 1'b0, 0, tag);
    endtask

    task automatic drop(input int k, input string tag);
        step(1'b0, 1'b0, 0, 1'b1, k, tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, 0, 1'b0, 0, tag);
    endtask

    // Monitor: compare just after the edge that applied each item
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                n_vec++;
                if (int'(lru_idx) != it.exp) begin
                    n_fail++;
                    $display("FAIL %s: lru_idx actual %0d expected %0d",
                             it.tag, lru_idx, it.exp);
                end
            end
        end
    end

    initial begin
        int seq [10] = '{0, 1, 2, 3, 2, 1, 0, 3, 2, 3};

        // R1: reset state
        step(1'b1, 1'b0, 0, 1'b0, 0, "R1");
        step(1'b1, 1'b1, 5, 1'b0, 0, "R1");
        idle("R6");

        // R3: untouched frames, lowest index first
        touch(0, "R3");
        touch(1, "R3");
        touch(3, "R3");
        // R2: given reference order
        for (int i = 0; i < 10; i++) touch(seq[i], "R2");
        for (int i = 4; i < N; i++) touch(i, "R2");
        idle("R6");
        touch(0, "R2");
        touch(0, "R2");

        // R4: drop makes frame the victim, others keep order
        drop(6, "R4");
        drop(2, "R4");
        touch(2, "R4");
        touch(6, "R4");

        // R5: drop wins over simultaneous touch
        step(1'b1, 1'b0, 0, 1'b0, 0, "R1");
        touch(1, "R5"); touch(2, "R5"); touch(4, "R5"); touch(5, "R5");
        touch(6, "R5"); touch(7, "R5"); touch(0, "R5");
        step(1'b0, 1'b1, 3, 1'b1, 5, "R5");
        touch(5, "R5");
        idle("R5");

        // R1: reset overrides traffic mid-run
        step(1'b1, 1'b0, 0, 1'b1, 4, "R1");
        idle("R1");

        // R3/R6: mixed random traffic
        for (int i = 0; i < 400; i++) begin
            int  ri = $urandom_range(N - 1);
            int  di = $urandom_range(N - 1);
            int  sel = $urandom_range(9);
            step(1'b0, sel < 6 || sel == 8, ri, sel >= 7, di, "R3");
        end

        repeat (3) @(posedge clk);
        #1;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule